// File: doc/BRIEF.md
# Trap Entry State-Stacking Unit

This unit holds the status and return-address state that a small 32-bit processor core needs when it enters and leaves a software trap. It keeps three copies of a three-bit status record: live, backup, and second-level backup. It also keeps two saved program counters: backup and second-level backup. Software moves values in and out of these through a control-register write port and a combinational read port.

When a trap with a 4-bit number is accepted, every saved copy moves one level deeper. The live status keeps only its stack-mode bit. The unit also presents the handler vector on a redirect output in the same cycle. A return input undoes one level of stacking and redirects to the saved return address.

The status record has three fields: stack mode (SM), interrupt enable (IE) and condition (COND). Control-register index 0 shows the live record in its low byte and the backup record in the next byte. Index 8 shows the second-level backup record. Index 6 is the backup PC and index 9 is the second-level backup PC.

Top module: `trap_stack_unit`

## Requirements
- R1: After reset, every register reads as zero at indices 0, 6, 8 and 9, and the redirect strobe is low.
- R2: Index 0 holds the live record (SM at bit 7, IE at bit 6, COND at bit 0) and the backup record (SM at bit 15, IE at bit 14, COND at bit 8). A write to index 0 reads back through those bit positions.
- R3: Index 8 holds the second-level record (SM at bit 7, IE at bit 6, COND at bit 0). The state {1,1,1} reads back as 0xC1.
- R4: Indices 6 (backup PC) and 9 (second-level backup PC) store and return all 32 bits of a write.
- R5: On trap entry, the second-level record takes the old backup record and the backup record takes the old live record.
- R6: On trap entry, live SM keeps its value while live IE and COND become 0. For example, live {1,1,1} with backup {0,0,0} reads 0xC180 at index 0 afterwards.
- R7: On trap entry, the second-level backup PC takes the old backup PC and the backup PC takes the trap instruction address plus 4.
- R8: In the cycle a trap is accepted, the redirect strobe is high and the redirect PC is 0x40 + 4 × trap number. For example, trap 2 gives 0x48, trap 0 gives 0x40 and trap 15 gives 0x7C.
- R9: Bits of indices 0 and 8 other than those named in R2 and R3 read as zero, and writing them has no effect. Indices other than 0, 6, 8 and 9 read as zero and ignore writes.
- R10: A return moves the backup record to live and the second-level record to backup, and leaves the second-level record and both PCs unchanged. In the same cycle the redirect strobe is high and the redirect PC is the backup PC with bits 1:0 cleared.
- R11: A trap wins over a return and over a register write in the same cycle. A return likewise wins over a register write. The losing action is dropped.
- R12: A register write takes effect in time for a trap in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctlWrEn | input | 1 | Control-register write strobe |
| ctlAddr | input | 4 | Control-register index for read and write |
| ctlWrData | input | 32 | Write data |
| ctlRdData | output | 32 | Read data for ctlAddr (combinational) |
| trapValid | input | 1 | Trap accepted this cycle |
| trapNum | input | 4 | Trap number |
| trapPc | input | 32 | Address of the trap instruction |
| rteValid | input | 1 | Return from exception this cycle |
| redirValid | output | 1 | PC redirect strobe |
| redirPc | output | 32 | PC redirect target |

## Verification
Three actions can collide in one cycle: trap entry, return, and a control-register write. The bench drives a trap together with a write of all ones to index 0, and separately a trap together with a return. It then reads indices 0 and 8 back. A correct result shows only the trap's shifted state and the trap vector on the redirect port, with no trace of the dropped action.

// File: rtl/trap_stack_pkg.sv
package trap_stack_pkg;

  typedef struct packed {
    logic sm;
    logic ie;
    logic cond;
  } stat_t;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CR0,
    SEL_CR8,
    SEL_BPC,
    SEL_BBPC
  } rsel_t;

  typedef struct packed {
    logic  doTrap;
    logic  doRte;
    logic  wrCr0;
    logic  wrCr8;
    logic  wrBpc;
    logic  wrBbpc;
    rsel_t rdSel;
  } strobe_t;

  localparam int SM_BIT   = 7;
  localparam int IE_BIT   = 6;
  localparam int COND_BIT = 0;
  localparam int BAK_OFS  = 8;

endpackage

// File: rtl/trap_stack_ctrl.sv
module trap_stack_ctrl
  import trap_stack_pkg::*;
#(
  parameter int AW        = 4,
  parameter int ADDR_CR0  = 0,
  parameter int ADDR_CR8  = 8,
  parameter int ADDR_BPC  = 6,
  parameter int ADDR_BBPC = 9
) (
  input  logic          ctlWrEn,
  input  logic [AW-1:0] ctlAddr,
  input  logic          trapValid,
  input  logic          rteValid,
  output strobe_t       strobes
);

  logic hitCr0, hitCr8, hitBpc, hitBbpc, wrAllowed;

  always_comb begin
    hitCr0    = (ctlAddr == AW'(ADDR_CR0));
    hitCr8    = (ctlAddr == AW'(ADDR_CR8));
    hitBpc    = (ctlAddr == AW'(ADDR_BPC));
    hitBbpc   = (ctlAddr == AW'(ADDR_BBPC));
    // trap beats return beats write
    wrAllowed = ctlWrEn && !trapValid && !rteValid;

    strobes.doTrap = trapValid;
    strobes.doRte  = rteValid && !trapValid;
    strobes.wrCr0  = wrAllowed && hitCr0;
    strobes.wrCr8  = wrAllowed && hitCr8;
    strobes.wrBpc  = wrAllowed && hitBpc;
    strobes.wrBbpc = wrAllowed && hitBbpc;

    if (hitCr0)       strobes.rdSel = SEL_CR0;
    else if (hitCr8)  strobes.rdSel = SEL_CR8;
    else if (hitBpc)  strobes.rdSel = SEL_BPC;
    else if (hitBbpc) strobes.rdSel = SEL_BBPC;
    else              strobes.rdSel = SEL_NONE;
  end

endmodule

// File: rtl/trap_stack_dp.sv
module trap_stack_dp
  import trap_stack_pkg::*;
#(
  parameter int             XLEN     = 32,
  parameter int             NUMW     = 4,
  parameter logic [XLEN-1:0] VEC_BASE = 'h40,
  parameter int             PC_STEP  = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strobes,
  input  logic [XLEN-1:0] ctlWrData,
  input  logic [NUMW-1:0] trapNum,
  input  logic [XLEN-1:0] trapPc,
  output logic [XLEN-1:0] ctlRdData,
  output logic            redirValid,
  output logic [XLEN-1:0] redirPc,
  output stat_t           liveSt,
  output stat_t           bakSt,
  output stat_t           deepSt,
  output logic [XLEN-1:0] bpcVal,
  output logic [XLEN-1:0] bbpcVal
);

  localparam int RECW = BAK_OFS;

  stat_t           liveQ, bakQ, deepQ;
  logic [XLEN-1:0] bpcQ, bbpcQ;

  function automatic logic [RECW-1:0] packStat(input stat_t s);
    logic [RECW-1:0] v;
    v           = '0;
    v[SM_BIT]   = s.sm;
    v[IE_BIT]   = s.ie;
    v[COND_BIT] = s.cond;
    return v;
  endfunction

  function automatic stat_t unpackStat(input logic [RECW-1:0] v);
    stat_t s;
    s.sm   = v[SM_BIT];
    s.ie   = v[IE_BIT];
    s.cond = v[COND_BIT];
    return s;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      liveQ <= '0;
      bakQ  <= '0;
      deepQ <= '0;
      bpcQ  <= '0;
      bbpcQ <= '0;
    end else if (strobes.doTrap) begin
      deepQ <= bakQ;
      bakQ  <= liveQ;
      liveQ <= '{sm: liveQ.sm, ie: 1'b0, cond: 1'b0};
      bbpcQ <= bpcQ;
      bpcQ  <= trapPc + XLEN'(PC_STEP);
    end else if (strobes.doRte) begin
      liveQ <= bakQ;
      bakQ  <= deepQ;
    end else begin
      if (strobes.wrCr0) begin
        liveQ <= unpackStat(ctlWrData[RECW-1:0]);
        bakQ  <= unpackStat(ctlWrData[2*RECW-1:RECW]);
      end
      if (strobes.wrCr8)  deepQ <= unpackStat(ctlWrData[RECW-1:0]);
      if (strobes.wrBpc)  bpcQ  <= ctlWrData;
      if (strobes.wrBbpc) bbpcQ <= ctlWrData;
    end
  end

  always_comb begin
    unique case (strobes.rdSel)
      SEL_CR0:  ctlRdData = XLEN'({packStat(bakQ), packStat(liveQ)});
      SEL_CR8:  ctlRdData = XLEN'(packStat(deepQ));
      SEL_BPC:  ctlRdData = bpcQ;
      SEL_BBPC: ctlRdData = bbpcQ;
      default:  ctlRdData = '0;
    endcase
  end

  always_comb begin
    redirValid = strobes.doTrap || strobes.doRte;
    if (strobes.doTrap)
      redirPc = VEC_BASE + XLEN'({trapNum, 2'b00});
    else if (strobes.doRte)
      redirPc = {bpcQ[XLEN-1:2], 2'b00};
    else
      redirPc = '0;
  end

  assign liveSt  = liveQ;
  assign bakSt   = bakQ;
  assign deepSt  = deepQ;
  assign bpcVal  = bpcQ;
  assign bbpcVal = bbpcQ;

endmodule

// File: rtl/trap_stack_unit.sv
module trap_stack_unit
  import trap_stack_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NUMW = 4,
  parameter int AW   = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            ctlWrEn,
  input  logic [AW-1:0]   ctlAddr,
  input  logic [XLEN-1:0] ctlWrData,
  output logic [XLEN-1:0] ctlRdData,
  input  logic            trapValid,
  input  logic [NUMW-1:0] trapNum,
  input  logic [XLEN-1:0] trapPc,
  input  logic            rteValid,
  output logic            redirValid,
  output logic [XLEN-1:0] redirPc
);

  strobe_t         strobes;
  stat_t           liveSt, bakSt, deepSt;
  logic [XLEN-1:0] bpcVal, bbpcVal;

  trap_stack_ctrl #(.AW(AW)) uCtrl (
    .ctlWrEn  (ctlWrEn),
    .ctlAddr  (ctlAddr),
    .trapValid(trapValid),
    .rteValid (rteValid),
    .strobes  (strobes)
  );

  trap_stack_dp #(.XLEN(XLEN), .NUMW(NUMW)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .ctlWrData (ctlWrData),
    .trapNum   (trapNum),
    .trapPc    (trapPc),
    .ctlRdData (ctlRdData),
    .redirValid(redirValid),
    .redirPc   (redirPc),
    .liveSt    (liveSt),
    .bakSt     (bakSt),
    .deepSt    (deepSt),
    .bpcVal    (bpcVal),
    .bbpcVal   (bbpcVal)
  );

endmodule

// File: rtl/trap_stack_chk.sv
module trap_stack_chk
  import trap_stack_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NUMW = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            trapValid,
  input logic [NUMW-1:0] trapNum,
  input logic [XLEN-1:0] trapPc,
  input logic            rteValid,
  input logic            redirValid,
  input logic [XLEN-1:0] redirPc,
  input stat_t           liveSt,
  input stat_t           bakSt,
  input stat_t           deepSt,
  input logic [XLEN-1:0] bpcVal,
  input logic [XLEN-1:0] bbpcVal
);

  AST_TRAP_SHIFT_STAT: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> (deepSt == $past(bakSt)) && (bakSt == $past(liveSt))); // R5

  AST_TRAP_LIVE_CLR: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> (liveSt.sm == $past(liveSt.sm)) && !liveSt.ie && !liveSt.cond); // R6

  AST_TRAP_SHIFT_PC: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> (bbpcVal == $past(bpcVal)) && (bpcVal == $past(trapPc) + XLEN'(4))); // R7

  AST_TRAP_VECTOR: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |-> redirValid && (redirPc == XLEN'('h40) + XLEN'({trapNum, 2'b00}))); // R8

  AST_RTE_UNSTACK: assert property (@(posedge clk) disable iff (!rstN)
    (rteValid && !trapValid) |=> (liveSt == $past(bakSt)) && (bakSt == $past(deepSt))
                                 && $stable(deepSt) && $stable(bpcVal) && $stable(bbpcVal)); // R10

  AST_RTE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (rteValid && !trapValid) |-> redirValid && (redirPc == {bpcVal[XLEN-1:2], 2'b00})); // R10

  AST_NO_SPURIOUS_REDIR: assert property (@(posedge clk) disable iff (!rstN)
    redirValid |-> (trapValid || rteValid)); // R11

endmodule

bind trap_stack_unit trap_stack_chk #(.XLEN(XLEN), .NUMW(NUMW)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .trapValid (trapValid),
  .trapNum   (trapNum),
  .trapPc    (trapPc),
  .rteValid  (rteValid),
  .redirValid(redirValid),
  .redirPc   (redirPc),
  .liveSt    (liveSt),
  .bakSt     (bakSt),
  .deepSt    (deepSt),
  .bpcVal    (bpcVal),
  .bbpcVal   (bbpcVal)
);

// File: tb/trap_stack_unit_test.sv
`timescale 1ns/1ps
module trap_stack_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctlWrEn = 1'b0;
  logic [3:0]  ctlAddr = '0;
  logic [31:0] ctlWrData = '0;
  logic [31:0] ctlRdData;
  logic        trapValid = 1'b0;
  logic [3:0]  trapNum = '0;
  logic [31:0] trapPc = '0;
  logic        rteValid = 1'b0;
  logic        redirValid;
  logic [31:0] redirPc;

  always #2.5 clk = ~clk;

  trap_stack_unit uut (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlAddr(ctlAddr),
    .ctlWrData(ctlWrData), .ctlRdData(ctlRdData), .trapValid(trapValid),
    .trapNum(trapNum), .trapPc(trapPc), .rteValid(rteValid),
    .redirValid(redirValid), .redirPc(redirPc)
  );

  // kind 1: compare read data; kind 2: compare {redirValid, redirPc}
  typedef struct {
    int          kind;
    logic [32:0] exp;
    string       tag;
  } item_t;

  item_t expQ[$];
  int    total = 0;
  int    bad   = 0;
  bit    done  = 1'b0;

  // one cycle of stimulus, with at most one expectation for that cycle
  task automatic step(input bit wr, input logic [3:0] addr, input logic [31:0] data,
                      input bit trap, input logic [3:0] num, input logic [31:0] pc,
                      input bit rte, input int kind, input logic [32:0] exp,
                      input string tag);
    item_t it;
    @(posedge clk);
    #1;
    ctlWrEn = wr; ctlAddr = addr; ctlWrData = data;
    trapValid = trap; trapNum = num; trapPc = pc; rteValid = rte;
    if (kind != 0) begin
      it.kind = kind; it.exp = exp; it.tag = tag;
      expQ.push_back(it);
    end
  endtask

  task automatic wrReg(input logic [3:0] a, input logic [31:0] d);
    step(1, a, d, 0, 0, 0, 0, 0, 0, "");
  endtask

  task automatic rdReg(input logic [3:0] a, input logic [31:0] e, input string tag);
    step(0, a, 0, 0, 0, 0, 0, 1, {1'b0, e}, tag);
  endtask

  task automatic trapGo(input logic [3:0] n, input logic [31:0] pc, input string tag);
    step(0, 0, 0, 1, n, pc, 0, 2, {1'b1, 32'h40 + {26'd0, n, 2'b00}}, tag);
  endtask

  // monitor: compares in the same cycle, at the falling edge
  always @(negedge clk) begin
    if (expQ.size() != 0) begin
      item_t it;
      logic [32:0] act;
      it  = expQ.pop_front();
      act = (it.kind == 1) ? {1'b0, ctlRdData} : {redirValid, redirPc};
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    step(0, 0, 0, 0, 0, 0, 0, 2, 33'd0, "R1 redirect idle");
    rdReg(0, 0, "R1 cr0");
    rdReg(8, 0, "R1 cr8");
    rdReg(6, 0, "R1 bpc");
    rdReg(9, 0, "R1 bbpc");

    // first trap scenario
    wrReg(8, 32'h0);
    wrReg(0, 32'hC100);
    wrReg(9, 32'd0);
    wrReg(6, 32'd42);
    rdReg(0, 32'hC100, "R2 cr0 readback");
    rdReg(6, 32'd42, "R4 bpc readback");
    trapGo(2, 32'h1000, "R8 trap 2 vector");
    rdReg(8, 32'hC1, "R5 R3 deep takes backup");
    rdReg(0, 32'h0, "R5 R6 cr0 after trap");
    rdReg(9, 32'd42, "R7 bbpc takes bpc");
    rdReg(6, 32'h1004, "R7 bpc return addr");

    // second trap scenario
    wrReg(8, 32'hC1);
    wrReg(0, 32'hC1);
    wrReg(9, 32'd42);
    wrReg(6, 32'd0);
    rdReg(9, 32'd42, "R4 bbpc readback");
    trapGo(2, 32'h2000, "R8 trap 2 vector again");
    rdReg(8, 32'h0, "R5 deep cleared");
    rdReg(0, 32'hC180, "R6 sm kept ie cond cleared");
    rdReg(9, 32'd0, "R7 bbpc");
    rdReg(6, 32'h2004, "R7 bpc");

    // R9 reserved bits and unmapped index
    wrReg(0, 32'hFFFF_FFFF);
    rdReg(0, 32'hC1C1, "R9 cr0 reserved bits");
    wrReg(8, 32'hFFFF_FFFF);
    rdReg(8, 32'hC1, "R9 cr8 reserved bits");
    wrReg(3, 32'h1234_5678);
    rdReg(3, 32'h0, "R9 unmapped index");
    rdReg(0, 32'hC1C1, "R9 cr0 untouched by unmapped write");
    rdReg(6, 32'h2004, "R9 bpc untouched by unmapped write");

    // R8 other trap numbers
    trapGo(15, 32'h3000, "R8 trap 15 vector");
    rdReg(0, 32'hC180, "R6 after trap 15");
    rdReg(9, 32'h2004, "R7 bbpc after trap 15");
    trapGo(0, 32'h3100, "R8 trap 0 vector");

    // R10 return
    wrReg(8, 32'h41);
    wrReg(0, 32'h8001);
    wrReg(6, 32'h1237);
    step(0, 0, 0, 0, 0, 0, 1, 2, {1'b1, 32'h1234}, "R10 return target");
    rdReg(0, 32'h4180, "R10 live and backup after return");
    rdReg(8, 32'h41, "R10 deep unchanged");
    rdReg(6, 32'h1237, "R10 bpc unchanged");

    // R11 trap with write in the same cycle
    step(1, 0, 32'hFFFF, 1, 1, 32'h500, 0, 2, {1'b1, 32'h44}, "R11 trap vector with write");
    rdReg(0, 32'h8080, "R11 write dropped");
    rdReg(8, 32'h41, "R11 deep from trap");
    // R11 trap with return in the same cycle
    step(0, 0, 0, 1, 3, 32'h600, 1, 2, {1'b1, 32'h4C}, "R11 trap beats return");
    rdReg(0, 32'h8080, "R11 cr0 after trap+return");
    rdReg(8, 32'h80, "R11 cr8 after trap+return");
    // R11 return with write in the same cycle
    step(1, 8, 32'hC1, 0, 0, 0, 1, 0, 0, "");
    rdReg(8, 32'h80, "R11 write dropped under return");

    // R12 write then trap in the next cycle
    wrReg(6, 32'h777);
    trapGo(4, 32'h900, "R12 trap right after write");
    rdReg(9, 32'h777, "R12 bbpc sees fresh write");
    rdReg(6, 32'h904, "R12 bpc");

    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule